// File: doc/BRIEF.md
# Menu-Driven SPI Flash Sequencer

This block is a register-programmed SPI master that runs one flash command per software start. Software loads a small menu of opcodes, a two-bit kind code for each menu entry, a pair of prefix opcodes, a 24-bit flash address and a byte buffer. It then writes the control register with the start bit set. The block sends the chosen opcode, then the address when the entry's kind calls for one, and then moves data bytes between the buffer and the flash. A prefix opcode (typically a write-enable) can be sent first as its own chip-select frame. No other command can be issued between that prefix and the main command.

Software uses a flat register port with 7-bit word addresses and 16-bit data. Reads are combinational. The map is: 0 status, 1 control (write only), 2 address bits 15:0, 3 address bits 23:16, 4 prefix pair, 5 kind codes, 6 to 9 menu words (word k holds entry 2k in bits 7:0 and entry 2k+1 in bits 15:8), and 64 to 127 the buffer, one byte per word in bits 7:0. The SPI side runs in mode 0. The clock idles low, data changes on the falling edge, the input is sampled on the rising edge, and every byte goes most significant bit first.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset the status register reads 0, chip select is high and the SPI clock is low.
- R2: A control write with bit 1 set starts a cycle. Status bit 0 (busy) reads 1 while the cycle runs. When the cycle ends, busy drops and status bit 2 (done) is set. Writing 1 to status bit 2 or bit 3 clears that bit.
- R3: The main frame begins with the menu entry selected by control bits 6:4, sent in SPI mode 0, most significant bit first.
- R4: The kind code for entry n sits in bits 2n+1:2n of register 5. The codes are: 0 read without address, 1 write without address, 2 read with address, 3 write with address. For codes 2 and 3 the three address bytes follow the opcode, most significant byte first. Codes 0 and 1 send no address.
- R5: When control bit 14 is set, the data phase moves (control bits 13:8) + 1 bytes. For write codes (1, 3), these bytes are sent from buffer byte 0 upward.
- R6: For read codes (0, 2), the bytes clocked in on the data line during the data phase are stored in the buffer from byte 0 upward.
- R7: When control bit 14 is clear, the frame holds only the opcode and, if the kind requires it, the address.
- R8: When control bit 2 is set, a one-byte prefix frame is sent first. It carries prefix bits 7:0 when control bit 3 is 0, and bits 15:8 when control bit 3 is 1. Chip select then stays high for at least two SPI clock periods before the main frame.
- R9: A start while a cycle is busy, or a start that asks for a prefix whose selected byte is zero, sets status bit 3 (error) and produces no SPI frame. A cycle already running goes on to its end.
- R10: Writing 1 to status bit 15 sets the lock, which only reset clears. While the lock is set, writes to the menu, kind and prefix registers leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Several properties are checked on every clock edge: the lock never falls and freezes the menu, the SPI clock is low whenever chip select is high or the shifter is idle, a start during a busy cycle is followed by the error bit, and the address and data byte counters never pass the third address byte or the programmed count. Other behaviour can only be seen in the bench scenarios, which watch the SPI pins through a flash model. These cover the byte order of opcode, address and data, where read bytes land in the buffer, the prefix frame and its high gap, the choice of prefix byte, and the check that a refused start or a locked write leaves no trace on the pins or in the registers.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;

   localparam int ADDR_W = 7;
   localparam int DATA_W = 16;

   localparam logic [ADDR_W-1:0] REG_STAT  = 7'd0;
   localparam logic [ADDR_W-1:0] REG_CTRL  = 7'd1;
   localparam logic [ADDR_W-1:0] REG_ADRL  = 7'd2;
   localparam logic [ADDR_W-1:0] REG_ADRH  = 7'd3;
   localparam logic [ADDR_W-1:0] REG_PFX   = 7'd4;
   localparam logic [ADDR_W-1:0] REG_KIND  = 7'd5;
   localparam logic [ADDR_W-1:0] REG_MENU0 = 7'd6;
   localparam logic [ADDR_W-1:0] BUF_BASE  = 7'd64;

   // control bit positions
   localparam int CB_GO   = 1;
   localparam int CB_ATOM = 2;
   localparam int CB_PSEL = 3;
   localparam int CB_IDX  = 4;
   localparam int CB_CNT  = 8;
   localparam int CB_DPH  = 14;

   // status bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_DONE = 2;
   localparam int SB_ERR  = 3;
   localparam int SB_LOCK = 15;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_GAP  = 2'd3
   } sq_state_e;

   typedef enum logic [1:0] {
      PH_OP  = 2'd0,
      PH_ADR = 2'd1,
      PH_DAT = 2'd2
   } sq_phase_e;

endpackage

// File: rtl/spi_menu_shift.sv
module spi_menu_shift #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] tx_i,
   input  logic       miso_i,
   output logic       sclk_o,
   output logic       mosi_o,
   output logic       done_o,
   output logic [7:0] rx_o
);

   logic       busy_q;
   logic       sclk_q;
   logic       done_q;
   logic [7:0] sh_q;
   logic [7:0] rx_q;
   logic [2:0] bit_q;
   logic       tick;

   generate
      if (HALF_DIV == 1) begin : g_fast
         assign tick = busy_q;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!busy_q || start_i) begin
               div_q <= '0;
            end else if (div_q == DW'(HALF_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = busy_q && (div_q == DW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         sh_q   <= '0;
         rx_q   <= '0;
         bit_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            sh_q   <= tx_i;
            bit_q  <= '0;
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[6:0], miso_i};
            end else begin
               sclk_q <= 1'b0;
               sh_q   <= {sh_q[6:0], 1'b0};
               if (bit_q == 3'd7) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk_o = sclk_q;
   assign mosi_o = sh_q[7];
   assign done_o = done_q;
   assign rx_o   = rx_q;

   // mode 0: clock rests low whenever no byte is in flight
   assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);

endmodule

// File: rtl/spi_menu_regs.sv
module spi_menu_regs
   import spi_menu_pkg::*;
#(
   parameter int MENU_N    = 8,
   parameter int BUF_BYTES = 64,
   localparam int BIDX_W   = $clog2(BUF_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic                   busy_i,
   input  logic                   done_set_i,
   input  logic                   err_set_i,
   input  logic                   seq_we_i,
   input  logic [BIDX_W-1:0]      seq_widx_i,
   input  logic [7:0]             seq_wdata_i,
   input  logic [BIDX_W-1:0]      seq_ridx_i,
   output logic [7:0]             seq_rdata_o,
   output logic [8*MENU_N-1:0]    menu_o,
   output logic [2*MENU_N-1:0]    kind_o,
   output logic [15:0]            pfx_o,
   output logic [23:0]            addr_o,
   output logic                   err_o
);

   localparam int WORDS = MENU_N / 2;

   logic [MENU_N-1:0][7:0] menu_q;
   logic [2*MENU_N-1:0]    kind_q;
   logic [15:0]            pfx_q;
   logic [23:0]            addr_q;
   logic                   done_q, err_q, lock_q;
   logic [7:0]             buf_q [BUF_BYTES];

   logic [ADDR_W-1:0] boff;
   logic              buf_hit;
   logic              stat_wr;

   assign boff    = bus_addr - BUF_BASE;
   assign buf_hit = (bus_addr >= BUF_BASE) && (boff < ADDR_W'(BUF_BYTES));
   assign stat_wr = bus_we && (bus_addr == REG_STAT);

   // protected configuration: menu, kinds, prefix pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         menu_q <= '0;
         kind_q <= '0;
         pfx_q  <= '0;
      end else if (bus_we && !lock_q) begin
         for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(REG_MENU0 + w)) begin
               menu_q[2*w]   <= bus_wdata[7:0];
               menu_q[2*w+1] <= bus_wdata[15:8];
            end
         end
         if (bus_addr == REG_KIND) kind_q <= bus_wdata[2*MENU_N-1:0];
         if (bus_addr == REG_PFX)  pfx_q  <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == REG_ADRL) addr_q[15:0]  <= bus_wdata;
         if (bus_addr == REG_ADRH) addr_q[23:16] <= bus_wdata[7:0];
      end
   end

   // status: clear-on-one, set by the sequencer wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         lock_q <= 1'b0;
      end else begin
         if (stat_wr && bus_wdata[SB_DONE]) done_q <= 1'b0;
         if (stat_wr && bus_wdata[SB_ERR])  err_q  <= 1'b0;
         if (stat_wr && bus_wdata[SB_LOCK]) lock_q <= 1'b1;
         if (done_set_i) done_q <= 1'b1;
         if (err_set_i)  err_q  <= 1'b1;
      end
   end

   // data buffer, sequencer port has priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
      end else if (seq_we_i) begin
         buf_q[seq_widx_i] <= seq_wdata_i;
      end else if (bus_we && buf_hit) begin
         buf_q[boff[BIDX_W-1:0]] <= bus_wdata[7:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == REG_STAT)
         bus_rdata = {lock_q, 11'b0, err_q, done_q, 1'b0, busy_i};
      else if (bus_addr == REG_ADRL)
         bus_rdata = addr_q[15:0];
      else if (bus_addr == REG_ADRH)
         bus_rdata = {8'h00, addr_q[23:16]};
      else if (bus_addr == REG_PFX)
         bus_rdata = pfx_q;
      else if (bus_addr == REG_KIND)
         bus_rdata = DATA_W'(kind_q);
      else if (buf_hit)
         bus_rdata = {8'h00, buf_q[boff[BIDX_W-1:0]]};
      for (int w = 0; w < WORDS; w++) begin
         if (bus_addr == ADDR_W'(REG_MENU0 + w))
            bus_rdata = {menu_q[2*w+1], menu_q[2*w]};
      end
   end

   assign seq_rdata_o = buf_q[seq_ridx_i];
   assign menu_o      = menu_q;
   assign kind_o      = kind_q;
   assign pfx_o       = pfx_q;
   assign addr_o      = addr_q;
   assign err_o       = err_q;

   assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   assert_menu_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(menu_q) && $stable(kind_q) && $stable(pfx_q)));

endmodule

// File: rtl/spi_menu_ctl.sv
module spi_menu_ctl
   import spi_menu_pkg::*;
#(
   parameter int MENU_N    = 8,
   parameter int BUF_BYTES = 64,
   parameter int GAP_CYC   = 8,
   localparam int IDX_W    = $clog2(MENU_N),
   localparam int CNT_W    = $clog2(BUF_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_i,
   input  logic                 want_pfx_i,
   input  logic                 pfx_hi_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic [CNT_W-1:0]     cnt_i,
   input  logic                 dph_i,
   input  logic [8*MENU_N-1:0]  menu_i,
   input  logic [2*MENU_N-1:0]  kind_i,
   input  logic [15:0]          pfx_i,
   input  logic [23:0]          addr_i,
   input  logic                 sh_done_i,
   input  logic [7:0]           sh_rx_i,
   input  logic [7:0]           buf_rdata_i,
   output logic                 busy_o,
   output logic                 done_set_o,
   output logic                 err_set_o,
   output logic                 cs_n_o,
   output logic                 sh_start_o,
   output logic [7:0]           sh_tx_o,
   output logic                 buf_we_o,
   output logic [CNT_W-1:0]     buf_idx_o,
   output logic [7:0]           buf_wdata_o
);

   localparam int GW = $clog2(GAP_CYC + 1);

   sq_state_e          state_q;
   sq_phase_e          phase_q;
   logic [CNT_W-1:0]   idx_q;
   logic [GW-1:0]      gap_q;
   logic               cs_q;
   logic               in_pfx_q;
   logic [7:0]         op_q;
   logic [1:0]         kind_q;
   logic [7:0]         pfxop_q;
   logic [23:0]        adr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               dph_q;

   logic [7:0] sel_pfx;
   logic       start_ok;
   logic       more;
   logic [7:0] cur_byte;

   always_comb begin
      sel_pfx  = pfx_hi_i ? pfx_i[15:8] : pfx_i[7:0];
      start_ok = go_i && (state_q == SQ_IDLE) && !(want_pfx_i && (sel_pfx == 8'h00));

      unique case (phase_q)
         PH_OP:   more = kind_q[1] || dph_q;
         PH_ADR:  more = (idx_q != CNT_W'(2)) || dph_q;
         default: more = (idx_q != cnt_q);
      endcase

      if (in_pfx_q) begin
         cur_byte = pfxop_q;
      end else begin
         unique case (phase_q)
            PH_OP:  cur_byte = op_q;
            PH_ADR: begin
               unique case (idx_q[1:0])
                  2'd0:    cur_byte = adr_q[23:16];
                  2'd1:    cur_byte = adr_q[15:8];
                  default: cur_byte = adr_q[7:0];
               endcase
            end
            default: cur_byte = buf_rdata_i;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         phase_q  <= PH_OP;
         idx_q    <= '0;
         gap_q    <= '0;
         cs_q     <= 1'b1;
         in_pfx_q <= 1'b0;
         op_q     <= '0;
         kind_q   <= '0;
         pfxop_q  <= '0;
         adr_q    <= '0;
         cnt_q    <= '0;
         dph_q    <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_ok) begin
                  op_q     <= menu_i[idx_i*8 +: 8];
                  kind_q   <= kind_i[idx_i*2 +: 2];
                  pfxop_q  <= sel_pfx;
                  adr_q    <= addr_i;
                  cnt_q    <= cnt_i;
                  dph_q    <= dph_i;
                  in_pfx_q <= want_pfx_i;
                  phase_q  <= PH_OP;
                  idx_q    <= '0;
                  cs_q     <= 1'b0;
                  state_q  <= SQ_LOAD;
               end
            end
            SQ_LOAD: state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (sh_done_i) begin
                  if (in_pfx_q) begin
                     in_pfx_q <= 1'b0;
                     cs_q     <= 1'b1;
                     gap_q    <= '0;
                     state_q  <= SQ_GAP;
                  end else if (!more) begin
                     cs_q    <= 1'b1;
                     state_q <= SQ_IDLE;
                  end else begin
                     state_q <= SQ_LOAD;
                     unique case (phase_q)
                        PH_OP: begin
                           phase_q <= kind_q[1] ? PH_ADR : PH_DAT;
                           idx_q   <= '0;
                        end
                        PH_ADR: begin
                           if (idx_q == CNT_W'(2)) begin
                              phase_q <= PH_DAT;
                              idx_q   <= '0;
                           end else begin
                              idx_q <= idx_q + 1'b1;
                           end
                        end
                        default: idx_q <= idx_q + 1'b1;
                     endcase
                  end
               end
            end
            default: begin
               if (gap_q == GW'(GAP_CYC - 1)) begin
                  cs_q    <= 1'b0;
                  state_q <= SQ_LOAD;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy_o      = (state_q != SQ_IDLE);
   assign err_set_o   = go_i && !start_ok;
   assign done_set_o  = (state_q == SQ_WAIT) && sh_done_i && !in_pfx_q && !more;
   assign cs_n_o      = cs_q;
   assign sh_start_o  = (state_q == SQ_LOAD);
   assign sh_tx_o     = cur_byte;
   assign buf_we_o    = (state_q == SQ_WAIT) && sh_done_i && !in_pfx_q &&
                        (phase_q == PH_DAT) && !kind_q[0];
   assign buf_idx_o   = idx_q;
   assign buf_wdata_o = sh_rx_i;

   assert_adr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && phase_q == PH_ADR) |-> (idx_q < CNT_W'(3)));

   assert_dat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && phase_q == PH_DAT) |-> (idx_q <= cnt_q));

   assert_gap_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_GAP) |-> cs_n_o);

endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
   import spi_menu_pkg::*;
#(
   parameter int HALF_DIV  = 2,
   parameter int MENU_N    = 8,
   parameter int BUF_BYTES = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [6:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        spi_sclk,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);

   localparam int IDX_W   = $clog2(MENU_N);
   localparam int CNT_W   = $clog2(BUF_BYTES);
   localparam int GAP_CYC = 4 * HALF_DIV;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (MENU_N != 2 && MENU_N != 4 && MENU_N != 8) begin : g_bad_menu
         $error("MENU_N must be 2, 4 or 8");
      end
      if (BUF_BYTES < 4 || BUF_BYTES > 64 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two from 4 to 64");
      end
   endgenerate

   logic                go;
   logic                busy, done_set, err_set, err_q;
   logic                sh_start, sh_done;
   logic [7:0]          sh_tx, sh_rx;
   logic                buf_we;
   logic [CNT_W-1:0]    buf_idx;
   logic [7:0]          buf_wdata, buf_rdata;
   logic [8*MENU_N-1:0] menu;
   logic [2*MENU_N-1:0] kind;
   logic [15:0]         pfx;
   logic [23:0]         addr;

   assign go = bus_we && (bus_addr == REG_CTRL) && bus_wdata[CB_GO];

   spi_menu_regs #(
      .MENU_N    (MENU_N),
      .BUF_BYTES (BUF_BYTES)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .busy_i      (busy),
      .done_set_i  (done_set),
      .err_set_i   (err_set),
      .seq_we_i    (buf_we),
      .seq_widx_i  (buf_idx),
      .seq_wdata_i (buf_wdata),
      .seq_ridx_i  (buf_idx),
      .seq_rdata_o (buf_rdata),
      .menu_o      (menu),
      .kind_o      (kind),
      .pfx_o       (pfx),
      .addr_o      (addr),
      .err_o       (err_q)
   );

   spi_menu_ctl #(
      .MENU_N    (MENU_N),
      .BUF_BYTES (BUF_BYTES),
      .GAP_CYC   (GAP_CYC)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .want_pfx_i  (bus_wdata[CB_ATOM]),
      .pfx_hi_i    (bus_wdata[CB_PSEL]),
      .idx_i       (bus_wdata[CB_IDX +: IDX_W]),
      .cnt_i       (bus_wdata[CB_CNT +: CNT_W]),
      .dph_i       (bus_wdata[CB_DPH]),
      .menu_i      (menu),
      .kind_i      (kind),
      .pfx_i       (pfx),
      .addr_i      (addr),
      .sh_done_i   (sh_done),
      .sh_rx_i     (sh_rx),
      .buf_rdata_i (buf_rdata),
      .busy_o      (busy),
      .done_set_o  (done_set),
      .err_set_o   (err_set),
      .cs_n_o      (spi_cs_n),
      .sh_start_o  (sh_start),
      .sh_tx_o     (sh_tx),
      .buf_we_o    (buf_we),
      .buf_idx_o   (buf_idx),
      .buf_wdata_o (buf_wdata)
   );

   spi_menu_shift #(
      .HALF_DIV (HALF_DIV)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sh_start),
      .tx_i    (sh_tx),
      .miso_i  (spi_miso),
      .sclk_o  (spi_sclk),
      .mosi_o  (spi_mosi),
      .done_o  (sh_done),
      .rx_o    (sh_rx)
   );

   assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   assert_go_busy_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (go && busy) |=> err_q);

endmodule

// File: tb/spi_menu_seq_bench.sv
module spi_menu_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_menu_seq u_spi_menu_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .spi_sclk  (spi_sclk),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso)
   );

   // ---------------- flash model ----------------
   logic [7:0] fr [4][80];
   int         fr_len [4];
   int         nfr = 0;
   int         pos = 0;
   int         bitc = 0;
   int         mpos = 0;
   int         mbit = 7;
   logic [7:0] cap = '0;
   logic [7:0] rtmp;
   time        last_rise = 0;
   time        gap_ns = 0;

   function automatic logic [7:0] resp_byte(input int p);
      return 8'(8'h3C + p * 17);
   endfunction

   always @(negedge spi_cs_n) begin
      if (nfr > 0) gap_ns = $time - last_rise;
      nfr  = nfr + 1;
      pos  = 0;
      bitc = 0;
      mpos = 0;
      mbit = 7;
      rtmp = resp_byte(0);
      spi_miso = rtmp[7];
   end

   always @(posedge spi_cs_n) last_rise = $time;

   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         cap  = {cap[6:0], spi_mosi};
         bitc = bitc + 1;
         if (bitc == 8) begin
            if (nfr >= 1 && nfr <= 4 && pos < 80) begin
               fr[nfr-1][pos] = cap;
               fr_len[nfr-1]  = pos + 1;
            end
            pos  = pos + 1;
            bitc = 0;
         end
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         if (mbit == 0) begin
            mbit = 7;
            mpos = mpos + 1;
         end else begin
            mbit = mbit - 1;
         end
         rtmp = resp_byte(mpos);
         spi_miso = rtmp[mbit];
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [15:0] ctl(input bit atom, input bit phi, input int idx,
                                       input int cnt_m1, input bit dph);
      return {1'b0, dph, 6'(cnt_m1), 1'b0, 3'(idx), phi, atom, 1'b1, 1'b0};
   endfunction

   task automatic wait_idle();
      logic [15:0] s;
      for (int k = 0; k < 4000; k++) begin
         bus_read(7'd0, s);
         if (!s[0]) break;
      end
   endtask

   task automatic clear_frames();
      nfr = 0;
      gap_ns = 0;
      for (int f = 0; f < 4; f++) fr_len[f] = 0;
   endtask

   task automatic run(input logic [15:0] c);
      clear_frames();
      bus_write(7'd0, 16'h000C);
      bus_write(7'd1, c);
      wait_idle();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [15:0] s;
      bus_read(7'd0, s);
      chk("R1", "status", s, 0);
      chk("R1", "cs_n", spi_cs_n, 1);
      chk("R1", "sclk", spi_sclk, 0);
   endtask

   task automatic t_read_noaddr();
      logic [15:0] s;
      clear_frames();
      bus_write(7'd1, ctl(0, 0, 3, 1, 1));
      bus_read(7'd0, s);
      chk("R2", "busy during cycle", s[0], 1);
      wait_idle();
      bus_read(7'd0, s);
      chk("R2", "done after cycle", s, 16'h0004);
      chk("R3", "frame count", nfr, 1);
      chk("R3", "opcode", fr[0][0], 8'h05);
      chk("R4", "no address frame length", fr_len[0], 3);
      bus_read(7'd64, s);
      chk("R6", "buf0", s, resp_byte(1));
      bus_read(7'd65, s);
      chk("R6", "buf1", s, resp_byte(2));
      bus_write(7'd0, 16'h0004);
      bus_read(7'd0, s);
      chk("R2", "done cleared", s, 0);
   endtask

   task automatic t_write_addr_atomic();
      logic [7:0] expv [8];
      expv = '{8'h02, 8'h12, 8'h34, 8'h56, 8'h11, 8'h22, 8'h33, 8'h44};
      bus_write(7'd4, 16'h5006);
      bus_write(7'd2, 16'h3456);
      bus_write(7'd3, 16'h0012);
      bus_write(7'd64, 16'h0011);
      bus_write(7'd65, 16'h0022);
      bus_write(7'd66, 16'h0033);
      bus_write(7'd67, 16'h0044);
      run(ctl(1, 0, 2, 3, 1));
      chk("R8", "frames", nfr, 2);
      chk("R8", "prefix length", fr_len[0], 1);
      chk("R8", "prefix low byte", fr[0][0], 8'h06);
      chk("R8", "gap at least two sclk", (gap_ns >= 80) ? 1 : 0, 1);
      chk("R5", "main length", fr_len[1], 8);
      for (int i = 0; i < 8; i++)
         chk(i < 4 ? "R4" : "R5", "main byte", fr[1][i], expv[i]);
   endtask

   task automatic t_read_addr();
      logic [15:0] s;
      bus_write(7'd2, 16'hCDEF);
      bus_write(7'd3, 16'h00AB);
      run(ctl(0, 0, 7, 5, 0));
      chk("R7", "length without data", fr_len[0], 4);
      chk("R7", "opcode", fr[0][0], 8'h03);
      chk("R4", "addr hi", fr[0][1], 8'hAB);
      chk("R4", "addr mid", fr[0][2], 8'hCD);
      chk("R4", "addr lo", fr[0][3], 8'hEF);
      run(ctl(0, 0, 7, 2, 1));
      chk("R6", "length with data", fr_len[0], 7);
      for (int i = 0; i < 3; i++) begin
         bus_read(7'(64 + i), s);
         chk("R6", "read buf", s, resp_byte(4 + i));
      end
   endtask

   task automatic t_prefix_hi();
      run(ctl(1, 1, 0, 0, 0));
      chk("R8", "frames", nfr, 2);
      chk("R8", "prefix high byte", fr[0][0], 8'h50);
      chk("R8", "main opcode", fr[1][0], 8'hC7);
      chk("R4", "kind 1 length", fr_len[1], 1);
   endtask

   task automatic t_errors();
      logic [15:0] s;
      bus_write(7'd4, 16'h0006);
      run(ctl(1, 1, 0, 0, 0));
      repeat (50) @(negedge clk);
      chk("R9", "zero prefix no frame", nfr, 0);
      bus_read(7'd0, s);
      chk("R9", "zero prefix error", s, 16'h0008);
      bus_write(7'd0, 16'h0008);
      bus_read(7'd0, s);
      chk("R2", "error cleared", s, 0);
      clear_frames();
      bus_write(7'd1, ctl(0, 0, 7, 7, 1));
      bus_write(7'd1, ctl(0, 0, 3, 0, 1));
      wait_idle();
      bus_read(7'd0, s);
      chk("R9", "busy go status", s, 16'h000C);
      chk("R9", "busy go one frame", nfr, 1);
      chk("R9", "first cycle intact", fr_len[0], 12);
   endtask

   task automatic t_lock();
      logic [15:0] s;
      bus_write(7'd0, 16'h800C);
      bus_read(7'd0, s);
      chk("R10", "lock set", s, 16'h8000);
      bus_write(7'd7, 16'h0000);
      bus_read(7'd7, s);
      chk("R10", "menu kept", s, 16'h0502);
      bus_write(7'd5, 16'h0000);
      bus_read(7'd5, s);
      chk("R10", "kind kept", s, 16'h8031);
      bus_write(7'd4, 16'h1111);
      bus_read(7'd4, s);
      chk("R10", "prefix kept", s, 16'h0006);
      run(ctl(0, 0, 3, 0, 1));
      chk("R10", "old opcode sent", fr[0][0], 8'h05);
      bus_write(7'd0, 16'h000C);
      bus_read(7'd0, s);
      chk("R10", "lock sticky", s, 16'h8000);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      bus_write(7'd6, 16'h9FC7);
      bus_write(7'd7, 16'h0502);
      bus_write(7'd8, 16'h0B20);
      bus_write(7'd9, 16'h03D8);
      bus_write(7'd5, 16'h8031);
      t_read_noaddr();
      t_write_addr_atomic();
      t_read_addr();
      t_prefix_hi();
      t_errors();
      t_lock();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule